// File: doc/BRIEF.md
# Receive descriptor ring index controller

This block keeps the device-side bookkeeping for a ring of receive buffer descriptors that lives in host memory. Software posts a write index telling the device how many empty buffers it has prepared. The block hands out the descriptor to fill next, opens a buffer when a frame begins, and closes that buffer once the line has been quiet for a programmable number of 32 microsecond ticks. Every close advances a published read index and can pulse an interrupt. Memory transfers are outside the block. It only produces indices, the open-buffer flag, the ring-full flag, the interrupt and the idle flag.

A configuration word sets these fields: ring size as a power of two, receive buffer size, interrupt target, close timeout and a run mode. The run mode can stop the channel at once or at the end of the frame that is in progress. When the read index equals the posted write index, the ring has no room, and arriving frames are dropped.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset the read index is 0, the ring reports full, no buffer is open, the interrupt is low, idle is high and the buffer size reads 4096. The configuration resets to stop mode, ring exponent 8, timeout 16 and interrupt target none.
- R2: The configuration word packs its fields as follows: run mode in bits [1:0], interrupt target in [3:2], buffer size code in [5:4], ring exponent in [9:6] and close timeout in [17:10]. The ring holds 2^exponent entries, with the exponent clamped to the range 5 to 12. The read index wraps at the ring size.
- R3: ring_full_o is high when the masked read index equals the write index. A frame start that arrives while no buffer is open and the ring is full is dropped, and no buffer opens.
- R4: A write to the write index rounds the value down to a multiple of 8 and masks it to the ring size.
- R5: In run mode (10), a frame start with no frame active opens a buffer at the read index if none is open. Later frames are added to the open buffer.
- R6: An open buffer with no frame active closes on the Nth tick after the last frame end, where N is the timeout and 0 counts as 1. A close advances the read index by one, modulo the ring size.
- R7: Each close gives a one-cycle irq_o pulse only when the interrupt target is 01. Target 00 gives no interrupt.
- R8: In pause-at-end mode (01), a frame in progress completes. The open buffer then closes, and only after that does idle assert.
- R9: In stop mode (00), or the unused code 11, idle asserts as soon as no frame is active. An open buffer stays open and its timer is frozen. Timing resumes when run mode returns.
- R10: rb_bytes_o reports the buffer size as 4096 × (code + 1), giving 4K, 8K, 12K or 16K.
- R11: Frame starts are ignored whenever the mode is not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 18 | Configuration word |
| wr_idx_we_i | input | 1 | Write-index write strobe |
| wr_idx_i | input | 12 | Write index posted by software |
| frame_start_i | input | 1 | Frame begins |
| frame_end_i | input | 1 | Frame ends |
| tick_32us_i | input | 1 | 32 microsecond tick pulse |
| rd_idx_o | output | 12 | Published read index, which is also the descriptor to fill |
| buf_open_o | output | 1 | A buffer is currently being filled |
| ring_full_o | output | 1 | No free descriptor is available |
| irq_o | output | 1 | Buffer-close interrupt pulse |
| idle_o | output | 1 | Channel has stopped |
| rb_bytes_o | output | 15 | Decoded receive buffer size in bytes |

## Verification
Directed sequences cover several cases:
- Exponent values below and above the legal range, which separate clamping from raw masking.
- Unaligned and oversized write indices, which separate rounding from masking.
- Timeouts of several lengths, which reveal any off-by-one tick count.
- Each mode change made in the middle of a frame, which separates the stop behaviour from the pause-at-end behaviour.

Seeded random runs then mix overlapping frame starts and ends, ticks, write-index posts and mode changes on a 32-entry ring. These runs push the read index through wrap and full many times, and a bench model tracks every output on every cycle.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int IDX_W       = 12;
  localparam int TO_W        = 8;
  localparam int LOG_MIN     = 5;
  localparam int LOG_MAX     = 12;
  localparam int WR_STEP_LOG = 3;
  localparam int RB_UNIT_LOG = 12;
  localparam int RB_W        = RB_UNIT_LOG + 3;

  typedef enum logic [1:0] {
    MODE_STOP      = 2'b00,
    MODE_PAUSE_EOF = 2'b01,
    MODE_RUN       = 2'b10,
    MODE_RSVD      = 2'b11
  } run_mode_e;

  typedef struct packed {
    logic [TO_W-1:0] close_to;
    logic [3:0]      ring_log;
    logic [1:0]      buf_size;
    logic [1:0]      irq_tgt;
    run_mode_e       mode;
  } rx_cfg_t;

  localparam int CFG_W = $bits(rx_cfg_t);

  localparam rx_cfg_t CFG_RST = '{close_to: TO_W'(16), ring_log: 4'd8,
                                  buf_size: 2'b00, irq_tgt: 2'b00,
                                  mode: MODE_STOP};
endpackage

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg
  import rx_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output run_mode_e        mode_o,
  output logic [1:0]       irq_tgt_o,
  output logic [IDX_W-1:0] idx_mask_o,
  output logic [TO_W-1:0]  to_lim_o,
  output logic [RB_W-1:0]  rb_bytes_o
);
  rx_cfg_t    cfg_q;
  logic [3:0] lg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= rx_cfg_t'(wdata_i);
  end

  always_comb begin
    if (cfg_q.ring_log < 4'(LOG_MIN))      lg = 4'(LOG_MIN);
    else if (cfg_q.ring_log > 4'(LOG_MAX)) lg = 4'(LOG_MAX);
    else                                   lg = cfg_q.ring_log;
  end

  assign mode_o     = cfg_q.mode;
  assign irq_tgt_o  = cfg_q.irq_tgt;
  assign idx_mask_o = IDX_W'((32'd1 << lg) - 32'd1);
  assign to_lim_o   = (cfg_q.close_to == '0) ? TO_W'(1) : cfg_q.close_to;
  assign rb_bytes_o = RB_W'((32'(cfg_q.buf_size) + 32'd1) << RB_UNIT_LOG);
endmodule

// File: rtl/rx_close_timer.sv
module rx_close_timer
  import rx_ring_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            cnt_en_i,
  input  logic [TO_W-1:0] lim_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;

  assign expire_o = cnt_en_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (cnt_en_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_ring_idx.sv
module rx_ring_idx
  import rx_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_we_i,
  input  logic [IDX_W-1:0] wr_i,
  input  logic [IDX_W-1:0] mask_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] rd_o,
  output logic             full_o
);
  logic [IDX_W-1:0] rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (adv_i)   rd_q <= (rd_q + 1'b1) & mask_i;
      if (wr_we_i) wr_q <= {wr_i[IDX_W-1:WR_STEP_LOG], {WR_STEP_LOG{1'b0}}} & mask_i;
    end
  end

  assign rd_o   = rd_q & mask_i;
  assign full_o = (rd_o == wr_q);

  assert_rd_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q != $past(rd_q)) |-> (rd_q == (($past(rd_q) + 1'b1) & $past(mask_i))));
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             wr_idx_we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             tick_32us_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             buf_open_o,
  output logic             ring_full_o,
  output logic             irq_o,
  output logic             idle_o,
  output logic [RB_W-1:0]  rb_bytes_o
);
  run_mode_e        mode;
  logic [1:0]       irq_tgt;
  logic [IDX_W-1:0] idx_mask;
  logic [TO_W-1:0]  to_lim;
  logic             in_frame_q, open_q, irq_q;
  logic             run, peof, acc, fend, cnt_en, expire, close;

  rx_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .mode_o    (mode),
    .irq_tgt_o (irq_tgt),
    .idx_mask_o(idx_mask),
    .to_lim_o  (to_lim),
    .rb_bytes_o(rb_bytes_o)
  );

  assign run    = (mode == MODE_RUN);
  assign peof   = (mode == MODE_PAUSE_EOF);
  assign acc    = frame_start_i && run && !in_frame_q && (open_q || !ring_full_o);
  assign fend   = frame_end_i && in_frame_q;
  assign cnt_en = tick_32us_i && open_q && !in_frame_q && run && !acc;
  // a new frame start keeps the buffer open even on an expiring tick
  assign close  = open_q && !in_frame_q && !acc && (peof || expire);

  rx_close_timer u_timer (
    .clk_i, .rst_ni,
    .clr_i   (fend || acc),
    .cnt_en_i(cnt_en),
    .lim_i   (to_lim),
    .expire_o(expire)
  );

  rx_ring_idx u_idx (
    .clk_i, .rst_ni,
    .wr_we_i(wr_idx_we_i),
    .wr_i   (wr_idx_i),
    .mask_i (idx_mask),
    .adv_i  (close),
    .rd_o   (rd_idx_o),
    .full_o (ring_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      open_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (fend)     in_frame_q <= 1'b0;
      else if (acc) in_frame_q <= 1'b1;
      if (acc)        open_q <= 1'b1;
      else if (close) open_q <= 1'b0;
      irq_q <= close && (irq_tgt == 2'b01);
    end
  end

  assign buf_open_o = open_q;
  assign irq_o      = irq_q;
  assign idle_o     = !run && !in_frame_q && !(peof && open_q);

  assert_no_fill_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(!ring_full_o));
  assert_irq_after_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ($past(open_q) && !open_q));
  assert_pause_eof_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peof && $fell(in_frame_q)) |=> !open_q);
  assert_start_needs_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_q) |-> $past(run));
endmodule

// File: tb/rx_ring_ctrl_bench.sv
`timescale 1ns/1ps
module rx_ring_ctrl_bench;
  import rx_ring_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cwe = 0, wwe = 0, fs = 0, fe = 0, tk = 0;
  logic [CFG_W-1:0] cwd = '0;
  logic [IDX_W-1:0] wv = '0;
  logic [IDX_W-1:0] rd_idx;
  logic buf_open, ring_full, irq, idle;
  logic [RB_W-1:0] rb_bytes;

  int vecs = 0, errs = 0;
  bit done = 0;
  int m_mode, m_tgt, m_bsz, m_log, m_to, m_wr, m_rd, m_tcnt;
  bit m_open, m_inf, m_irq;
  int n_mode, n_tgt, n_bsz, n_log, n_to;

  always #2 clk = ~clk;

  rx_ring_ctrl u_rx_ring_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cwe), .cfg_wdata_i(cwd),
    .wr_idx_we_i(wwe), .wr_idx_i(wv),
    .frame_start_i(fs), .frame_end_i(fe), .tick_32us_i(tk),
    .rd_idx_o(rd_idx), .buf_open_o(buf_open), .ring_full_o(ring_full),
    .irq_o(irq), .idle_o(idle), .rb_bytes_o(rb_bytes)
  );

  function automatic int mask_of(int lg);
    int l = (lg < 5) ? 5 : ((lg > 12) ? 12 : lg);
    return (1 << l) - 1;
  endfunction

  function automatic int rb_of(int b);
    return 4096 * (b + 1);
  endfunction

  task automatic check(string req, int got, int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_cfg(int md, int tg, int bs, int lg, int to);
    cwe = 1;
    cwd = {to[7:0], lg[3:0], bs[1:0], tg[1:0], md[1:0]};
    n_mode = md; n_tgt = tg; n_bsz = bs; n_log = lg; n_to = to;
  endtask

  task automatic step();
    int  mask  = mask_of(m_log);
    bit  run   = (m_mode == 2);
    bit  full  = ((m_rd & mask) == m_wr);
    bit  acc   = fs && run && !m_inf && (m_open || !full);
    int  tol   = (m_to == 0) ? 1 : m_to;
    bit  cen   = tk && m_open && !m_inf && run && !acc;
    bit  expd  = cen && (m_tcnt + 1 >= tol);
    bit  close = m_open && !m_inf && !acc && (m_mode == 1 || expd);
    int  mk;
    m_irq = close && (m_tgt == 1);
    if (close) begin m_rd = (m_rd + 1) & mask; m_open = 0; end
    if (m_inf && fe)        begin m_inf = 0; m_tcnt = 0; end
    else if (acc)           begin m_inf = 1; m_open = 1; m_tcnt = 0; end
    else if (cen && !expd)  m_tcnt++;
    if (wwe) m_wr = (int'(wv) & ~7) & mask;
    if (cwe) begin m_mode = n_mode; m_tgt = n_tgt; m_bsz = n_bsz; m_log = n_log; m_to = n_to; end
    @(posedge clk); #1;
    mk = mask_of(m_log);
    check("R6 read index", int'(rd_idx), m_rd & mk);
    check("R3 ring full", int'(ring_full), int'((m_rd & mk) == m_wr));
    check("R5 buffer open", int'(buf_open), int'(m_open));
    check("R7 interrupt", int'(irq), int'(m_irq));
    check("R8 R9 idle", int'(idle), int'(m_mode != 2 && !m_inf && !(m_mode == 1 && m_open)));
    check("R10 buffer bytes", int'(rb_bytes), rb_of(m_bsz));
    cwe = 0; wwe = 0; fs = 0; fe = 0; tk = 0;
  endtask

  task automatic post_wr(int v);
    wwe = 1; wv = IDX_W'(v); step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mode = 0; m_tgt = 0; m_bsz = 0; m_log = 8; m_to = 16;
    m_wr = 0; m_rd = 0; m_tcnt = 0; m_open = 0; m_inf = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 rd", int'(rd_idx), 0);
    check("R1 full", int'(ring_full), 1);
    check("R1 open", int'(buf_open), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 idle", int'(idle), 1);
    check("R1 bytes", int'(rb_bytes), 4096);

    // R2 exponent clamp and field layout
    set_cfg(2, 1, 0, 3, 3); step();
    post_wr(8);  check("R2 low clamp keeps 8", int'(ring_full), 0);
    set_cfg(2, 1, 0, 6, 3); step();
    post_wr(64); check("R2 64 entry ring wraps", int'(ring_full), 1);
    set_cfg(2, 1, 0, 15, 3); step();
    post_wr(4088); check("R2 high clamp keeps 4088", int'(ring_full), 0);

    // R10 buffer size decode
    set_cfg(2, 1, 1, 8, 3); step(); check("R10 8K", int'(rb_bytes), 8192);
    set_cfg(2, 1, 3, 8, 3); step(); check("R10 16K", int'(rb_bytes), 16384);
    set_cfg(2, 1, 0, 8, 3); step();

    // R3 drop when full
    post_wr(0);
    fs = 1; step(); check("R3 no open when full", int'(buf_open), 0);
    fe = 1; step();

    // R4 rounding and masking
    post_wr(13);  check("R4 13 rounds to 8", int'(ring_full), 0);
    post_wr(7);   check("R4 7 rounds to 0", int'(ring_full), 1);
    post_wr(264); check("R4 264 masks to 8", int'(ring_full), 0);
    post_wr(16);

    // R5 R6 R7 timeout close with host interrupt
    fs = 1; step(); check("R5 open on start", int'(buf_open), 1);
    fe = 1; step();
    tk = 1; step(); tk = 1; step();
    check("R6 still open after 2 ticks", int'(buf_open), 1);
    tk = 1; step();
    check("R6 closed on 3rd tick", int'(buf_open), 0);
    check("R6 rd advanced", int'(rd_idx), 1);
    check("R7 irq pulse", int'(irq), 1);
    step(); check("R7 one cycle", int'(irq), 0);

    // R7 target none
    set_cfg(2, 0, 0, 8, 1); step();
    fs = 1; step(); fe = 1; step(); tk = 1; step();
    check("R7 no irq for target 00", int'(irq), 0);
    check("R6 timeout 1 closes", int'(rd_idx), 2);

    // R8 pause at end of frame
    set_cfg(2, 1, 0, 8, 5); step();
    fs = 1; step();
    set_cfg(1, 1, 0, 8, 5); step();
    check("R8 busy in frame", int'(idle), 0);
    fe = 1; step();
    check("R8 not idle before close", int'(idle), 0);
    step();
    check("R8 closed", int'(buf_open), 0);
    check("R8 idle after close", int'(idle), 1);
    check("R8 irq", int'(irq), 1);

    // R9 R11 stop keeps buffer open and ignores frames
    set_cfg(2, 1, 0, 8, 3); step();
    fs = 1; step(); fe = 1; step();
    set_cfg(0, 1, 0, 8, 3); step();
    check("R9 idle in stop", int'(idle), 1);
    fs = 1; step();
    check("R11 start ignored", int'(idle), 1);
    repeat (5) begin tk = 1; step(); end
    check("R9 buffer held", int'(buf_open), 1);
    check("R9 rd frozen", int'(rd_idx), 3);
    set_cfg(2, 1, 0, 8, 3); step();
    repeat (3) begin tk = 1; step(); end
    check("R9 resumes and closes", int'(rd_idx), 4);

    // random phase on a 32-entry ring
    set_cfg(2, 1, 0, 5, 2); step();
    for (int i = 0; i < 4000; i++) begin
      if (i % 300 == 150)
        set_cfg(($urandom % 6 < 3) ? 2 : int'($urandom % 4), int'($urandom % 2),
                int'($urandom % 4), 5, int'($urandom % 4));
      fs = ($urandom % 4 == 0);
      fe = ($urandom % 4 == 0);
      tk = ($urandom % 3 == 0);
      if ($urandom % 20 == 0) begin wwe = 1; wv = IDX_W'($urandom); end
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule